// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a registered 32-bit arithmetic unit that performs saturating arithmetic chosen by a 4-bit opcode. It covers signed add and subtract that clamp to the signed range, a signed doubling that clamps, unsigned add and subtract that clamp to all-ones or zero, and a plain wrapping add that still reports signed overflow. It also clamps a value to a programmable bit position, either signed or unsigned, and either on the whole word or on the two 16-bit halves independently.

Whenever an operation has to clamp its result, a sticky saturation flag is set. The flag stays set until the dedicated clear input is pulsed or the block is reset, and it can be read in every cycle. A result is presented one clock after an operation is issued with `in_valid`. The result holds its value until the next operation.

Top module: `sat_unit`

## Requirements
- R1: An operation issued with `in_valid` high on a rising edge appears on `result` with `out_valid` high right after that edge. `out_valid` is low after any edge where `in_valid` was low. `result` keeps its value while no operation is issued.
- R2: Opcode 0 (signed saturating add) returns a+b. If both operands have the same sign and the sum's sign differs, it returns 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative.
- R3: Opcode 1 (signed saturating subtract) returns a-b. If the operand signs differ and the difference's sign differs from a, it clamps with the same sign rule as R2.
- R4: Opcode 2 (signed doubling) returns a shifted left by one. A signed input of 0x40000000 or more gives 0x7FFFFFFF. A signed input of 0xC0000000 or less gives 0x80000000. Both limits count as clamps.
- R5: Opcode 3 (unsigned add) returns 0xFFFFFFFF when the sum carries out. Opcode 4 (unsigned subtract) returns 0 when b > a. Otherwise each returns the exact result.
- R6: Opcode 5 (wrapping add) always returns the 32-bit wrapped sum. It sets the flag when the signed sum overflows under the rule of R2.
- R7: Opcode 6 (signed clamp to position n = `sat_pos`) takes a as signed. It returns 2^n-1 when a > 2^n-1, returns -(2^n) when a < -(2^n), and otherwise returns a.
- R8: Opcode 7 (unsigned clamp to position n) returns 0 when a is negative as a signed value, returns 2^n-1 when a > 2^n-1, and otherwise returns a.
- R9: Opcodes 8 (signed) and 9 (unsigned) split a into two halves: bits 15:0 and bits 31:16. Each half is sign-extended and clamped on its own with the same n under R7 or R8 respectively. The low 16 bits of each lane's result are packed back into that half. A clamp in either lane counts.
- R10: Any clamp under R2–R9, and any overflow under R6, sets `sat_flag` on the edge that captures the result. An operation that does not clamp leaves the flag as it was. `clr_flag` clears the flag on the next edge. If a clamping operation arrives on the same edge as `clr_flag`, the flag ends up set.
- R11: After synchronous reset, `result` is 0, `out_valid` is 0 and `sat_flag` is 0.
- R12: Opcodes 10 to 15 return 0 and leave `sat_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue the operation on the current inputs |
| opcode | input | 4 | Operation select, encodings as in R2–R9 and R12 |
| opnd_a | input | 32 | First operand, or the value to clamp |
| opnd_b | input | 32 | Second operand for add and subtract |
| sat_pos | input | 5 | Clamp position n for opcodes 6–9 |
| clr_flag | input | 1 | Clear the sticky saturation flag |
| result | output | 32 | Registered result |
| out_valid | output | 1 | Result was updated by the last edge |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check the following on every cycle:
- the timing of `out_valid`, and that `result` holds while the unit is idle;
- that the flag never drops unless a clear was requested, that it only rises alongside an issued operation, and that a clear with no operation leaves it low;
- that unsigned add never returns less than a, and that unsigned subtract never returns more than a;
- that a signed add of two non-negative operands never yields a negative result.

The exact clamp limits are shown only by the bench's directed scenarios. These include the doubling thresholds, the limits at each bit position, the independence of the two halves, the same-edge clear-versus-set order and the handling of unused opcodes.

// File: rtl/satu_pkg.sv
package satu_pkg;

    localparam int unsigned SATU_OPC_W = 4;

    typedef enum logic [SATU_OPC_W-1:0] {
        OPC_ADD_S  = 4'd0,
        OPC_SUB_S  = 4'd1,
        OPC_DBL_S  = 4'd2,
        OPC_ADD_U  = 4'd3,
        OPC_SUB_U  = 4'd4,
        OPC_ADD_WQ = 4'd5,
        OPC_CLP_S  = 4'd6,
        OPC_CLP_U  = 4'd7,
        OPC_CLP_S2 = 4'd8,
        OPC_CLP_U2 = 4'd9
    } satu_opc_e;

    typedef enum logic [2:0] {
        AR_ADD_S  = 3'd0,
        AR_SUB_S  = 3'd1,
        AR_DBL_S  = 3'd2,
        AR_ADD_U  = 3'd3,
        AR_SUB_U  = 3'd4,
        AR_ADD_WQ = 3'd5
    } satu_arith_e;

    // Decoded control for one operation
    typedef struct packed {
        logic        legal;
        logic        use_clamp;
        logic        clamp_signed;
        logic        dual;
        satu_arith_e arith;
    } satu_ctl_t;

    function automatic satu_ctl_t satu_decode(logic [SATU_OPC_W-1:0] op);
        satu_ctl_t c;
        c = '{legal: 1'b1, use_clamp: 1'b0, clamp_signed: 1'b0,
              dual: 1'b0, arith: AR_ADD_S};
        case (op)
            OPC_ADD_S:  c.arith = AR_ADD_S;
            OPC_SUB_S:  c.arith = AR_SUB_S;
            OPC_DBL_S:  c.arith = AR_DBL_S;
            OPC_ADD_U:  c.arith = AR_ADD_U;
            OPC_SUB_U:  c.arith = AR_SUB_U;
            OPC_ADD_WQ: c.arith = AR_ADD_WQ;
            OPC_CLP_S:  begin c.use_clamp = 1'b1; c.clamp_signed = 1'b1; end
            OPC_CLP_U:  begin c.use_clamp = 1'b1; end
            OPC_CLP_S2: begin c.use_clamp = 1'b1; c.clamp_signed = 1'b1; c.dual = 1'b1; end
            OPC_CLP_U2: begin c.use_clamp = 1'b1; c.dual = 1'b1; end
            default:    c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sat_arith.sv
module sat_arith
    import satu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  satu_arith_e       sel,
    output logic [DATA_W-1:0] value,
    output logic              clip
);
    localparam int unsigned MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] S_MAX  = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] Q_POS  = {2'b01, {(DATA_W-2){1'b0}}};
    localparam logic [DATA_W-1:0] Q_NEG  = {2'b11, {(DATA_W-2){1'b0}}};

    logic [DATA_W:0]   usum, udiff;
    logic [DATA_W-1:0] sum, diff, sign_lim, dbl;
    logic              add_ovf, sub_ovf, carry, borrow, dbl_hi, dbl_lo;

    always_comb begin
        usum     = {1'b0, a} + {1'b0, b};
        udiff    = {1'b0, a} - {1'b0, b};
        sum      = usum[MSB:0];
        diff     = udiff[MSB:0];
        carry    = usum[DATA_W];
        borrow   = udiff[DATA_W];
        add_ovf  = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sub_ovf  = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        sign_lim = a[MSB] ? S_MIN : S_MAX;
        dbl      = {a[MSB-1:0], 1'b0};
        dbl_hi   = $signed(a) >= $signed(Q_POS);
        dbl_lo   = $signed(a) <= $signed(Q_NEG);
    end

    always_comb begin
        value = sum;
        clip  = 1'b0;
        case (sel)
            AR_ADD_S: begin
                value = add_ovf ? sign_lim : sum;
                clip  = add_ovf;
            end
            AR_SUB_S: begin
                value = sub_ovf ? sign_lim : diff;
                clip  = sub_ovf;
            end
            AR_DBL_S: begin
                if (dbl_hi)      value = S_MAX;
                else if (dbl_lo) value = S_MIN;
                else             value = dbl;
                clip = dbl_hi || dbl_lo;
            end
            AR_ADD_U: begin
                value = carry ? {DATA_W{1'b1}} : sum;
                clip  = carry;
            end
            AR_SUB_U: begin
                value = borrow ? '0 : diff;
                clip  = borrow;
            end
            AR_ADD_WQ: begin
                value = sum;
                clip  = add_ovf;
            end
            default: begin
                value = sum;
                clip  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = 5
) (
    input  logic [DATA_W-1:0] val,
    input  logic [POS_W-1:0]  pos,
    input  logic              is_signed,
    output logic [DATA_W-1:0] y,
    output logic              clip
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] mask;
    logic signed [DATA_W-1:0] top;
    logic top_pos, top_low;

    always_comb begin
        mask    = (ONE << pos) - ONE;
        top     = $signed(val) >>> pos;
        top_pos = (top > 0);
        top_low = (top < -1);
    end

    always_comb begin
        y    = val;
        clip = 1'b0;
        if (is_signed) begin
            if (top_pos) begin
                y    = mask;
                clip = 1'b1;
            end else if (top_low) begin
                y    = ~mask;
                clip = 1'b1;
            end
        end else begin
            if (val[DATA_W-1]) begin
                y    = '0;
                clip = 1'b1;
            end else if (val > mask) begin
                y    = mask;
                clip = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
    import satu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [SATU_OPC_W-1:0] opcode,
    input  logic [DATA_W-1:0]     opnd_a,
    input  logic [DATA_W-1:0]     opnd_b,
    input  logic [$clog2(DATA_W)-1:0] sat_pos,
    input  logic                  clr_flag,
    output logic [DATA_W-1:0]     result,
    output logic                  out_valid,
    output logic                  sat_flag
);
    localparam int unsigned POS_W  = $clog2(DATA_W);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned LANES  = 3;   // whole word, low half, high half

    satu_ctl_t         ctl;
    logic [DATA_W-1:0] ar_val;
    logic              ar_clip;
    logic [DATA_W-1:0] lane_in  [LANES];
    logic [DATA_W-1:0] lane_y   [LANES];
    logic              lane_clip[LANES];
    logic [DATA_W-1:0] nxt_val;
    logic              nxt_clip;

    assign ctl = satu_decode(opcode);

    sat_arith #(.DATA_W(DATA_W)) arith_i (
        .a     (opnd_a),
        .b     (opnd_b),
        .sel   (ctl.arith),
        .value (ar_val),
        .clip  (ar_clip)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_word
            assign lane_in[g] = opnd_a;
        end else if (g == 1) begin : g_lo
            assign lane_in[g] = {{(DATA_W-HALF_W){opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};
        end else begin : g_hi
            assign lane_in[g] = {{(DATA_W-HALF_W){opnd_a[DATA_W-1]}}, opnd_a[DATA_W-1:HALF_W]};
        end
        sat_clamp #(.DATA_W(DATA_W), .POS_W(POS_W)) clamp_i (
            .val       (lane_in[g]),
            .pos       (sat_pos),
            .is_signed (ctl.clamp_signed),
            .y         (lane_y[g]),
            .clip      (lane_clip[g])
        );
    end

    always_comb begin
        nxt_val  = '0;
        nxt_clip = 1'b0;
        if (!ctl.legal) begin
            nxt_val  = '0;
            nxt_clip = 1'b0;
        end else if (!ctl.use_clamp) begin
            nxt_val  = ar_val;
            nxt_clip = ar_clip;
        end else if (ctl.dual) begin
            nxt_val  = {lane_y[2][HALF_W-1:0], lane_y[1][HALF_W-1:0]};
            nxt_clip = lane_clip[1] || lane_clip[2];
        end else begin
            nxt_val  = lane_y[0];
            nxt_clip = lane_clip[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
            sat_flag  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= nxt_val;
            sat_flag <= (sat_flag && !clr_flag) || (in_valid && nxt_clip);
        end
    end
endmodule

// File: rtl/sat_unit_chk.sv
module sat_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic [3:0]                opcode,
    input logic [DATA_W-1:0]         opnd_a,
    input logic [DATA_W-1:0]         opnd_b,
    input logic                      clr_flag,
    input logic [DATA_W-1:0]         result,
    input logic                      out_valid,
    input logic                      sat_flag
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (sat_flag && !clr_flag) |=> sat_flag);
    a_r10_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !in_valid) |=> !sat_flag);
    a_r10_rise_needs_op: assert property (@(posedge clk) disable iff (rst)
        (!sat_flag && !in_valid) |=> !sat_flag);
    a_r5_uadd_not_below: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'd3) |=> (result >= $past(opnd_a)));
    a_r5_usub_not_above: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'd4) |=> (result <= $past(opnd_a)));
    a_r2_pos_sum_stays_pos: assert property (@(posedge clk) disable iff (rst)
        (in_valid && opcode == 4'd0 && !opnd_a[DATA_W-1] && !opnd_b[DATA_W-1])
        |=> !result[DATA_W-1]);
endmodule

bind sat_unit sat_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .clr_flag  (clr_flag),
    .result    (result),
    .out_valid (out_valid),
    .sat_flag  (sat_flag)
);

// File: tb/sat_unit_tb_top.sv
module sat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  opcode;
    logic [31:0] opnd_a, opnd_b;
    logic [4:0]  sat_pos;
    logic        clr_flag;
    logic [31:0] result;
    logic        out_valid;
    logic        sat_flag;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  exp_flag = 1'b0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    sat_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_pos(sat_pos),
        .clr_flag(clr_flag), .result(result), .out_valid(out_valid),
        .sat_flag(sat_flag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Independent model built from the requirement text
    function automatic void clamp_s(input longint v, input int n,
                                    output longint r, output bit s);
        longint hi = (longint'(1) << n) - 1;
        longint lo = -(longint'(1) << n);
        s = 1'b1;
        if (v > hi)      r = hi;
        else if (v < lo) r = lo;
        else begin r = v; s = 1'b0; end
    endfunction

    function automatic void clamp_u(input longint v, input int n,
                                    output longint r, output bit s);
        longint hi = (longint'(1) << n) - 1;
        s = 1'b1;
        if (v < 0)       r = 0;
        else if (v > hi) r = hi;
        else begin r = v; s = 1'b0; end
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input int n,
                                  output logic [31:0] r, output bit s);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint t, lo_r, hi_r;
        bit s1, s2;
        s = 1'b0;
        r = '0;
        case (op)
            4'd0, 4'd5: begin
                t = sa + sb;
                r = 32'(t);
                if (t > 64'sh7FFFFFFF || t < -64'sh80000000) begin
                    s = 1'b1;
                    if (op == 4'd0) r = (sa >= 0) ? 32'h7FFFFFFF : 32'h80000000;
                end
            end
            4'd1: begin
                t = sa - sb;
                r = 32'(t);
                if (t > 64'sh7FFFFFFF || t < -64'sh80000000) begin
                    s = 1'b1;
                    r = (sa >= 0) ? 32'h7FFFFFFF : 32'h80000000;
                end
            end
            4'd2: begin
                if (sa >= 64'sh40000000)       begin r = 32'h7FFFFFFF; s = 1'b1; end
                else if (sa <= -64'sh40000000) begin r = 32'h80000000; s = 1'b1; end
                else r = 32'(sa * 2);
            end
            4'd3: begin
                t = ua + ub;
                if (t > 64'hFFFFFFFF) begin r = 32'hFFFFFFFF; s = 1'b1; end
                else r = 32'(t);
            end
            4'd4: begin
                if (ub > ua) begin r = 32'h0; s = 1'b1; end
                else r = 32'(ua - ub);
            end
            4'd6: begin clamp_s(sa, n, t, s); r = 32'(t); end
            4'd7: begin clamp_u(sa, n, t, s); r = 32'(t); end
            4'd8, 4'd9: begin
                if (op == 4'd8) begin
                    clamp_s(longint'($signed(a[15:0])), n, lo_r, s1);
                    clamp_s(longint'($signed(a[31:16])), n, hi_r, s2);
                end else begin
                    clamp_u(longint'($signed(a[15:0])), n, lo_r, s1);
                    clamp_u(longint'($signed(a[31:16])), n, hi_r, s2);
                end
                r = {16'(hi_r), 16'(lo_r)};
                s = s1 | s2;
            end
            default: begin r = '0; s = 1'b0; end
        endcase
    endfunction

    task automatic apply(input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] n,
                         input bit clr, input string req);
        logic [31:0] er;
        bit es;
        model(op, a, b, int'(n), er, es);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; opnd_a = a; opnd_b = b;
        sat_pos = n; clr_flag = clr;
        @(negedge clk);
        in_valid = 1'b0; clr_flag = 1'b0;
        exp_flag = (exp_flag && !clr) || es;
        check(req, "result", result, er);
        check(req, "out_valid", {31'b0, out_valid}, 32'd1);
        check(req, "flag", {31'b0, sat_flag}, {31'b0, exp_flag});
    endtask

    task automatic clear_flag(input string req);
        logic [31:0] held;
        held = result;
        @(negedge clk); clr_flag = 1'b1;
        @(negedge clk); clr_flag = 1'b0;
        exp_flag = 1'b0;
        check(req, "flag after clear", {31'b0, sat_flag}, 32'd0);
        check(req, "result kept over clear", result, held);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; clr_flag = 1'b0;
        opcode = '0; opnd_a = '0; opnd_b = '0; sat_pos = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_flag = 1'b0;
        check("R11", "result", result, 32'h0);
        check("R11", "out_valid", {31'b0, out_valid}, 32'd0);
        check("R11", "flag", {31'b0, sat_flag}, 32'd0);
    endtask

    task automatic t_signed_add();
        apply(4'd0, 32'd5, 32'd7, 5'd0, 1'b0, "R2");
        apply(4'd0, 32'hFFFFFFFE, 32'd1, 5'd0, 1'b0, "R2");
        apply(4'd0, 32'h7FFFFFF0, 32'h20, 5'd0, 1'b0, "R2");
        clear_flag("R10");
        apply(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1'b0, "R2");
        clear_flag("R10");
    endtask

    task automatic t_signed_sub();
        apply(4'd1, 32'd10, 32'd3, 5'd0, 1'b0, "R3");
        apply(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, "R3");
        clear_flag("R10");
        apply(4'd1, 32'h80000001, 32'd2, 5'd0, 1'b0, "R3");
        clear_flag("R10");
        apply(4'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 5'd0, 1'b0, "R3");
    endtask

    task automatic t_double();
        apply(4'd2, 32'h3FFFFFFF, 32'd0, 5'd0, 1'b0, "R4");
        apply(4'd2, 32'hC0000001, 32'd0, 5'd0, 1'b0, "R4");
        apply(4'd2, 32'h40000000, 32'd0, 5'd0, 1'b0, "R4");
        clear_flag("R10");
        apply(4'd2, 32'hC0000000, 32'd0, 5'd0, 1'b0, "R4");
        clear_flag("R10");
    endtask

    task automatic t_unsigned();
        apply(4'd3, 32'hFFFFFFF0, 32'h0F, 5'd0, 1'b0, "R5");
        apply(4'd3, 32'hFFFFFFF0, 32'h10, 5'd0, 1'b0, "R5");
        clear_flag("R10");
        apply(4'd4, 32'd9, 32'd9, 5'd0, 1'b0, "R5");
        apply(4'd4, 32'd9, 32'd10, 5'd0, 1'b0, "R5");
        clear_flag("R10");
    endtask

    task automatic t_wrap_add();
        apply(4'd5, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, "R6");
        clear_flag("R10");
        apply(4'd5, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0, "R6");
    endtask

    task automatic t_clamp_word();
        apply(6'd6, 32'd200, 32'd0, 5'd7, 1'b0, "R7");
        clear_flag("R10");
        apply(4'd6, 32'hFFFFFF00, 32'd0, 5'd7, 1'b0, "R7");
        clear_flag("R10");
        apply(4'd6, 32'hFFFFFF80, 32'd0, 5'd7, 1'b0, "R7");
        apply(4'd6, 32'h7FFFFFFF, 32'd0, 5'd31, 1'b0, "R7");
        apply(4'd7, 32'hFFFFFFFF, 32'd0, 5'd8, 1'b0, "R8");
        clear_flag("R10");
        apply(4'd7, 32'd300, 32'd0, 5'd8, 1'b0, "R8");
        clear_flag("R10");
        apply(4'd7, 32'd255, 32'd0, 5'd8, 1'b0, "R8");
        apply(4'd7, 32'd1, 32'd0, 5'd0, 1'b0, "R8");
        clear_flag("R10");
    endtask

    task automatic t_halves();
        apply(4'd8, 32'h7FFF8000, 32'd0, 5'd7, 1'b0, "R9");
        clear_flag("R10");
        apply(4'd8, 32'h00050080, 32'd0, 5'd7, 1'b0, "R9");
        clear_flag("R10");
        apply(4'd8, 32'h80007FFF, 32'd0, 5'd15, 1'b0, "R9");
        apply(4'd9, 32'h0100FFFF, 32'd0, 5'd8, 1'b0, "R9");
        clear_flag("R10");
        apply(4'd9, 32'h00FF0012, 32'd0, 5'd8, 1'b0, "R9");
    endtask

    task automatic t_flag_rules();
        apply(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0, "R10");
        apply(4'd0, 32'd1, 32'd1, 5'd0, 1'b0, "R10");
        apply(4'd3, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b1, "R10");
        apply(4'd3, 32'd1, 32'd1, 5'd0, 1'b1, "R10");
    endtask

    task automatic t_idle_hold();
        logic [31:0] held;
        apply(4'd0, 32'h12345678, 32'h1, 5'd0, 1'b0, "R1");
        held = result;
        repeat (3) @(negedge clk);
        check("R1", "held result", result, held);
        check("R1", "idle out_valid", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_bad_opcode();
        apply(4'd2, 32'h40000000, 32'd0, 5'd0, 1'b0, "R12");
        for (int k = 10; k < 16; k++)
            apply(4'(k), 32'hDEADBEEF, 32'h7, 5'd3, 1'b0, "R12");
        clear_flag("R10");
        apply(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0, "R12");
    endtask

    initial begin
        t_reset();
        t_signed_add();
        t_signed_sub();
        t_double();
        t_unsigned();
        t_wrap_add();
        t_clamp_word();
        t_halves();
        t_flag_rules();
        t_idle_hold();
        t_bad_opcode();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule